// File: doc/BRIEF.md
# Multi-lane LED slice serializer

This block shifts pixel colour data out onto several single-wire addressable-LED data lines at once. One timing engine drives every lane. It cuts each bit period into equal slices and produces one registered parallel word per clock, holding the level of every lane. The slice length is the greatest common divisor of the three pulse segments (first high part, optional extra high part, trailing low part). With the default 250/500/500 ns segments this gives five 250 ns slices per 1.25 µs bit. A '0' stays high for one slice and a '1' stays high for three.

Pixels arrive on a valid/ready stream, one beat per pixel position. Each beat carries one 24-bit colour word for every lane, with start-of-frame and end-of-frame markers. A frame always has exactly `PIXELS` beats. Completion is reported through a countdown of the bits still to be sent, not at the time the final beat is accepted. The block then holds every lane low for a latch gap before it takes the next frame. If data runs dry in the middle of a frame, the lanes go low at the next bit boundary and a sticky underrun flag is raised. No high level is ever stretched.

Top module: `led_slice_serializer`

## Requirements
- R1: The slice length is the GCD of the three segment lengths, and a slice lasts SLICE_DIV = slice/clock-period cycles (25 at the defaults). A bit lasts SPB slices (5 at the defaults), so within a frame consecutive bits start every SPB·SLICE_DIV cycles.
- R2: A '0' bit is high for HIGH0 = seg1/slice slices and a '1' bit for HIGH1 = (seg1+seg2)/slice slices (1 and 3 at the defaults). The bit is low for the rest of its period.
- R3: `lanes_o` is a registered word, and every bit of every lane starts high on the same clock edge, so no lane ever rises alone.
- R4: Lane l takes bits [24l+23:24l] of a beat. They are sent from bit 23 down to bit 0, which means green [23:16], then red [15:8], then blue [7:0], each channel MSB first.
- R5: A frame is exactly PIXELS beats, and every lane emits exactly PIXELS·24 bits with no truncated tail. Once PIXELS beats have been accepted, `px_ready_o` stays low until the latch gap has ended.
- R6: `frame_done_o` is a one-cycle pulse. It rises SPB·SLICE_DIV cycles after the final bit of the frame rises on the wire, which is the edge on which that bit's last slice ends.
- R7: After `frame_done_o`, all lanes stay low and `px_ready_o` stays low for GAP_SLICES·SLICE_DIV − 1 further cycles. GAP_SLICES is the gap length rounded up to whole slices (more than 50 µs at the defaults).
- R8: If a pixel finishes mid-frame while no next beat is held, the lanes stay low from the next slice onward and `underrun_o` rises and stays high until reset. Sending resumes at a bit boundary once data arrives, and the frame bit count is unchanged.
- R9: While idle, a beat without the start marker is accepted and dropped. It produces no lane activity.
- R10: `frame_err_o` is set and stays high until reset when an end marker is missing from the PIXELS-th beat, appears on any other beat, or a start marker appears on a beat inside a frame.
- R11: After reset, `lanes_o` is 0, `px_ready_o` is 1, and `frame_done_o`, `underrun_o` and `frame_err_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| px_valid_i | input | 1 | Pixel beat valid |
| px_ready_o | output | 1 | Pixel beat accepted when high together with valid |
| px_data_i | input | LANES·24 | One GRB word per lane, lane l at [24l+23:24l] |
| px_sof_i | input | 1 | Beat is the first of a frame |
| px_eof_i | input | 1 | Beat is the last of a frame |
| lanes_o | output | LANES | Current level of every LED data lane |
| frame_done_o | output | 1 | One-cycle pulse when the final bit has left the wire |
| underrun_o | output | 1 | Sticky: data ran dry mid-frame |
| frame_err_o | output | 1 | Sticky: start/end marker misplaced |

## Verification
A lane first rises three cycles after its start-of-frame beat is taken: one cycle to hold the beat, one to load the shifters and one for the output register. After that, every result is timed from the wire itself. The bench decodes every lane at the falling clock edge, turning high widths into bits and checking the spacing between rising edges. It checks the done pulse against the last observed rise, SPB·SLICE_DIV cycles later. The ready-low window is counted starting in the cycle where done is seen. Sticky flags and quiet lanes are sampled only after the window in which they could have changed has passed in full.

// File: rtl/led_ser_pkg.sv
package led_ser_pkg;

  localparam int PIX_BITS = 24;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_SEND = 2'd1,
    ST_GAP  = 2'd2
  } ser_state_e;

  function automatic int led_gcd(input int a, input int b);
    int x;
    int y;
    int t;
    x = a;
    y = b;
    while (y != 0) begin
      t = x % y;
      x = y;
      y = t;
    end
    return x;
  endfunction

endpackage

// File: rtl/led_slice_timer.sv
module led_slice_timer #(
  parameter int DIV  = 25,
  parameter int SPB  = 5,
  parameter int SL_W = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            run_i,
  output logic            slice_tick_o,
  output logic            bit_end_o,
  output logic [SL_W-1:0] slice_idx_o
);

  localparam int DIV_W = $clog2(DIV + 1);
  localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(DIV - 1);
  localparam logic [SL_W-1:0]  SL_LAST  = SL_W'(SPB - 1);

  logic [DIV_W-1:0] div_q, div_d;
  logic [SL_W-1:0]  sl_q, sl_d;

  assign slice_tick_o = run_i && (div_q == DIV_LAST);
  assign bit_end_o    = slice_tick_o && (sl_q == SL_LAST);
  assign slice_idx_o  = sl_q;

  always_comb begin
    div_d = div_q;
    sl_d  = sl_q;
    if (!run_i) begin
      div_d = '0;
      sl_d  = '0;
    end else if (slice_tick_o) begin
      div_d = '0;
      sl_d  = (sl_q == SL_LAST) ? '0 : sl_q + SL_W'(1);
    end else begin
      div_d = div_q + DIV_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q <= '0;
      sl_q  <= '0;
    end else begin
      div_q <= div_d;
      sl_q  <= sl_d;
    end
  end

  // R1
  slice_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bit_end_o |=> (sl_q == '0));

  // R1
  slice_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sl_q <= SL_LAST) && (div_q <= DIV_LAST));

endmodule

// File: rtl/led_lane_shift.sv
module led_lane_shift #(
  parameter int W = 24
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load_i,
  input  logic         shift_i,
  input  logic [W-1:0] data_i,
  output logic         msb_o
);

  logic [W-1:0] sh_q, sh_d;
  logic         sh_en;

  assign sh_en = load_i || shift_i;
  assign msb_o = sh_q[W-1];

  always_comb begin
    if (load_i) sh_d = data_i;
    else        sh_d = {sh_q[W-2:0], 1'b0};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     sh_q <= '0;
    else if (sh_en) sh_q <= sh_d;
  end

endmodule

// File: rtl/led_frame_ctrl.sv
module led_frame_ctrl
  import led_ser_pkg::*;
#(
  parameter int PIXELS     = 480,
  parameter int GAP_SLICES = 204,
  parameter int DATA_W     = 144
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              px_valid_i,
  output logic              px_ready_o,
  input  logic [DATA_W-1:0] px_data_i,
  input  logic              px_sof_i,
  input  logic              px_eof_i,
  input  logic              slice_tick_i,
  input  logic              bit_end_i,
  output logic              timer_run_o,
  output logic              load_o,
  output logic              shift_o,
  output logic [DATA_W-1:0] load_data_o,
  output logic              bit_live_o,
  output logic              frame_done_o,
  output logic              underrun_o,
  output logic              frame_err_o
);

  localparam int FRAME_BITS = PIXELS * PIX_BITS;
  localparam int ACC_W      = $clog2(PIXELS + 1);
  localparam int BITS_W     = $clog2(FRAME_BITS + 1);
  localparam int IDX_W      = $clog2(PIX_BITS);
  localparam int GAP_W      = $clog2(GAP_SLICES + 1);
  localparam logic [ACC_W-1:0]  PIX_CNT   = ACC_W'(PIXELS);
  localparam logic [ACC_W-1:0]  PIX_LAST  = ACC_W'(PIXELS - 1);
  localparam logic [BITS_W-1:0] BITS_INIT = BITS_W'(FRAME_BITS);
  localparam logic [IDX_W-1:0]  IDX_LAST  = IDX_W'(PIX_BITS - 1);
  localparam logic [GAP_W-1:0]  GAP_LAST  = GAP_W'(GAP_SLICES - 1);
  localparam logic              ONE_PIX   = (PIXELS == 1);

  ser_state_e        state_q, state_d;
  logic              hold_vld_q, hold_vld_d;
  logic [DATA_W-1:0] hold_q, hold_d;
  logic [ACC_W-1:0]  acc_cnt_q, acc_cnt_d;
  logic [BITS_W-1:0] bits_left_q, bits_left_d;
  logic [IDX_W-1:0]  bit_idx_q, bit_idx_d;
  logic [GAP_W-1:0]  gap_cnt_q, gap_cnt_d;
  logic              bit_live_q, bit_live_d;
  logic              done_pend_q, done_pend_d;
  logic              done_q, done_d;
  logic              underrun_q, underrun_d;
  logic              err_q, err_d;

  logic accept, bend, pix_end, last_bit;

  assign px_ready_o  = (state_q == ST_IDLE) ||
                       ((state_q == ST_SEND) && !hold_vld_q && (acc_cnt_q < PIX_CNT));
  assign accept      = px_valid_i && px_ready_o;
  assign bend        = bit_live_q && bit_end_i;
  assign pix_end     = bend && (bit_idx_q == IDX_LAST);
  assign last_bit    = bend && (bits_left_q == BITS_W'(1));
  assign load_o      = (state_q == ST_SEND) && hold_vld_q &&
                       (!bit_live_q || (pix_end && !last_bit));
  assign shift_o     = (state_q == ST_SEND) && bend && !pix_end;
  assign load_data_o = hold_q;
  assign timer_run_o = bit_live_q || (state_q == ST_GAP);
  assign bit_live_o  = bit_live_q;
  assign frame_done_o = done_q;
  assign underrun_o  = underrun_q;
  assign frame_err_o = err_q;

  always_comb begin
    state_d     = state_q;
    hold_vld_d  = hold_vld_q;
    hold_d      = hold_q;
    acc_cnt_d   = acc_cnt_q;
    bits_left_d = bits_left_q;
    bit_idx_d   = bit_idx_q;
    gap_cnt_d   = gap_cnt_q;
    bit_live_d  = bit_live_q;
    done_pend_d = 1'b0;
    done_d      = done_pend_q;
    underrun_d  = underrun_q;
    err_d       = err_q;
    unique case (state_q)
      ST_IDLE: begin
        if (accept && px_sof_i) begin
          state_d     = ST_SEND;
          hold_vld_d  = 1'b1;
          hold_d      = px_data_i;
          acc_cnt_d   = ACC_W'(1);
          bits_left_d = BITS_INIT;
          bit_idx_d   = '0;
          if (px_eof_i != ONE_PIX) err_d = 1'b1;
        end
      end
      ST_SEND: begin
        if (accept) begin
          hold_vld_d = 1'b1;
          hold_d     = px_data_i;
          acc_cnt_d  = acc_cnt_q + ACC_W'(1);
          if (px_sof_i || (px_eof_i != (acc_cnt_q == PIX_LAST))) err_d = 1'b1;
        end
        if (bend) begin
          bits_left_d = bits_left_q - BITS_W'(1);
          if (last_bit) begin
            bit_live_d  = 1'b0;
            state_d     = ST_GAP;
            gap_cnt_d   = '0;
            done_pend_d = 1'b1;
          end else if (pix_end) begin
            bit_idx_d = '0;
            if (!hold_vld_q) begin
              bit_live_d = 1'b0;
              underrun_d = 1'b1;
            end
          end else begin
            bit_idx_d = bit_idx_q + IDX_W'(1);
          end
        end
        if (load_o) begin
          hold_vld_d = 1'b0;
          bit_live_d = 1'b1;
          bit_idx_d  = '0;
        end
      end
      ST_GAP: begin
        if (slice_tick_i) begin
          if (gap_cnt_q == GAP_LAST) state_d = ST_IDLE;
          else                       gap_cnt_d = gap_cnt_q + GAP_W'(1);
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q     <= ST_IDLE;
      hold_vld_q  <= 1'b0;
      acc_cnt_q   <= '0;
      bits_left_q <= '0;
      bit_idx_q   <= '0;
      gap_cnt_q   <= '0;
      bit_live_q  <= 1'b0;
      done_pend_q <= 1'b0;
      done_q      <= 1'b0;
      underrun_q  <= 1'b0;
      err_q       <= 1'b0;
    end else begin
      state_q     <= state_d;
      hold_vld_q  <= hold_vld_d;
      acc_cnt_q   <= acc_cnt_d;
      bits_left_q <= bits_left_d;
      bit_idx_q   <= bit_idx_d;
      gap_cnt_q   <= gap_cnt_d;
      bit_live_q  <= bit_live_d;
      done_pend_q <= done_pend_d;
      done_q      <= done_d;
      underrun_q  <= underrun_d;
      err_q       <= err_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      hold_q <= '0;
    else if (accept) hold_q <= hold_d;
  end

  // R6
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done_o |=> !frame_done_o);

  // R5
  done_drained_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done_o |-> (state_q == ST_GAP) && !bit_live_q && (bits_left_q == '0));

  // R5
  hold_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_vld_q && !load_o) |=> hold_vld_q);

  // R8
  underrun_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(underrun_q) |-> (state_q == ST_SEND) && !bit_live_q);

endmodule

// File: rtl/led_slice_serializer.sv
module led_slice_serializer
  import led_ser_pkg::*;
#(
  parameter int LANES    = 6,
  parameter int PIXELS   = 480,
  parameter int CLK_NS   = 10,
  parameter int SEG_A_NS = 250,
  parameter int SEG_B_NS = 500,
  parameter int SEG_C_NS = 500,
  parameter int GAP_NS   = 51000
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      px_valid_i,
  output logic                      px_ready_o,
  input  logic [LANES*PIX_BITS-1:0] px_data_i,
  input  logic                      px_sof_i,
  input  logic                      px_eof_i,
  output logic [LANES-1:0]          lanes_o,
  output logic                      frame_done_o,
  output logic                      underrun_o,
  output logic                      frame_err_o
);

  localparam int SLICE_NS   = led_gcd(led_gcd(SEG_A_NS, SEG_B_NS), SEG_C_NS);
  localparam int SLICE_DIV  = SLICE_NS / CLK_NS;
  localparam int SPB        = (SEG_A_NS + SEG_B_NS + SEG_C_NS) / SLICE_NS;
  localparam int GAP_SLICES = (GAP_NS + SLICE_NS - 1) / SLICE_NS;
  localparam int SL_W       = $clog2(SPB + 1);
  localparam int DATA_W     = LANES * PIX_BITS;
  localparam logic [SL_W-1:0] HIGH0 = SL_W'(SEG_A_NS / SLICE_NS);
  localparam logic [SL_W-1:0] HIGH1 = SL_W'((SEG_A_NS + SEG_B_NS) / SLICE_NS);

  logic [1:0]        rst_sync_q;
  logic              rst_n_int;
  logic              slice_tick, bit_end, timer_run;
  logic [SL_W-1:0]   slice_idx;
  logic              load, shift, bit_live;
  logic [DATA_W-1:0] load_data;
  logic [LANES-1:0]  msb;
  logic [LANES-1:0]  word_d, lanes_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_int = rst_sync_q[1];

  led_slice_timer #(.DIV(SLICE_DIV), .SPB(SPB), .SL_W(SL_W)) u_timer (
    .clk          (clk),
    .rst_n        (rst_n_int),
    .run_i        (timer_run),
    .slice_tick_o (slice_tick),
    .bit_end_o    (bit_end),
    .slice_idx_o  (slice_idx)
  );

  led_frame_ctrl #(.PIXELS(PIXELS), .GAP_SLICES(GAP_SLICES), .DATA_W(DATA_W)) u_ctrl (
    .clk          (clk),
    .rst_n        (rst_n_int),
    .px_valid_i   (px_valid_i),
    .px_ready_o   (px_ready_o),
    .px_data_i    (px_data_i),
    .px_sof_i     (px_sof_i),
    .px_eof_i     (px_eof_i),
    .slice_tick_i (slice_tick),
    .bit_end_i    (bit_end),
    .timer_run_o  (timer_run),
    .load_o       (load),
    .shift_o      (shift),
    .load_data_o  (load_data),
    .bit_live_o   (bit_live),
    .frame_done_o (frame_done_o),
    .underrun_o   (underrun_o),
    .frame_err_o  (frame_err_o)
  );

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    led_lane_shift #(.W(PIX_BITS)) u_shift (
      .clk     (clk),
      .rst_n   (rst_n_int),
      .load_i  (load),
      .shift_i (shift),
      .data_i  (load_data[l*PIX_BITS +: PIX_BITS]),
      .msb_o   (msb[l])
    );
    assign word_d[l] = bit_live && (slice_idx < (msb[l] ? HIGH1 : HIGH0));
  end

  always_ff @(posedge clk or negedge rst_n_int) begin
    if (!rst_n_int) lanes_q <= '0;
    else            lanes_q <= word_d;
  end
  assign lanes_o = lanes_q;

  // R3
  lockstep_rise_chk: assert property (@(posedge clk) disable iff (!rst_n_int)
    (bit_live && (slice_idx == '0)) |=> (lanes_o == '1));

  // R8
  quiet_lanes_chk: assert property (@(posedge clk) disable iff (!rst_n_int)
    !bit_live |=> (lanes_o == '0));

endmodule

// File: tb/test_led_slice_serializer.sv
module test_led_slice_serializer;

  localparam int L   = 6;
  localparam int PX  = 2;
  localparam int D   = 2;
  localparam int SPB = 5;
  localparam int H0  = 1;
  localparam int H1  = 3;
  localparam int G   = 5;
  localparam int NB  = PX * 24;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic           px_valid = 1'b0;
  logic           px_ready;
  logic [L*24-1:0] px_data = '0;
  logic           px_sof = 1'b0;
  logic           px_eof = 1'b0;
  logic [L-1:0]   lanes;
  logic           frame_done, underrun, frame_err;

  led_slice_serializer #(
    .LANES(L), .PIXELS(PX), .CLK_NS(10),
    .SEG_A_NS(20), .SEG_B_NS(40), .SEG_C_NS(40), .GAP_NS(100)
  ) i_led_slice_serializer (
    .clk(clk), .rst_n(rst_n), .px_valid_i(px_valid), .px_ready_o(px_ready),
    .px_data_i(px_data), .px_sof_i(px_sof), .px_eof_i(px_eof),
    .lanes_o(lanes), .frame_done_o(frame_done), .underrun_o(underrun),
    .frame_err_o(frame_err)
  );

  always #5 clk = ~clk;

  int n_checks = 0;
  int n_fails  = 0;
  int cyc      = 0;
  always @(posedge clk) cyc <= cyc + 1;

  // wire monitor
  logic [L-1:0] prev_lv = '0;
  int  hi_len [L];
  logic dec [L][128];
  int  dec_n [L];
  int  anom = 0, lock_err = 0, per_err = 0;
  int  last_rise0 = -1000;
  logic [L*24-1:0] fr [PX];

  task automatic clear_mon();
    for (int l = 0; l < L; l++) begin
      dec_n[l] = 0;
      hi_len[l] = 0;
    end
    anom = 0; lock_err = 0; per_err = 0;
  endtask

  always @(negedge clk) begin
    logic [L-1:0] rises;
    rises = lanes & ~prev_lv;
    if (rises != '0 && rises != '1) lock_err++;
    if (rises[0]) begin
      if ((cyc - last_rise0) < 2*SPB*D && (cyc - last_rise0) != SPB*D) per_err++;
      last_rise0 = cyc;
    end
    for (int l = 0; l < L; l++) begin
      if (lanes[l]) hi_len[l]++;
      else if (prev_lv[l]) begin
        if (dec_n[l] < 128) begin
          if (hi_len[l] == H1*D) begin dec[l][dec_n[l]] = 1'b1; dec_n[l]++; end
          else if (hi_len[l] == H0*D) begin dec[l][dec_n[l]] = 1'b0; dec_n[l]++; end
          else anom++;
        end
        hi_len[l] = 0;
      end
    end
    prev_lv = lanes;
  end

  task automatic chk(input string req, input longint act, input longint exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic push(input logic [L*24-1:0] d, input logic s, input logic e);
    @(negedge clk);
    px_valid = 1'b1; px_data = d; px_sof = s; px_eof = e;
    while (!px_ready) @(negedge clk);
    @(posedge clk);
    @(negedge clk);
    px_valid = 1'b0; px_sof = 1'b0; px_eof = 1'b0;
  endtask

  // waits for done, then measures the gap; checks R6, R7
  task automatic wait_done_and_gap(input string tag);
    int n;
    int busy;
    int done_cyc;
    n = 0; busy = 0;
    while (!frame_done) @(negedge clk);
    done_cyc = cyc;
    chk({tag, " R6 done delay after last rise"}, done_cyc - last_rise0, SPB*D);
    while (!px_ready) begin
      if (lanes != '0) busy++;
      n++;
      @(negedge clk);
      if (frame_done) chk({tag, " R6 done one cycle wide"}, 1, 0);
    end
    chk({tag, " R7 ready-low gap cycles"}, n, G*D - 1);
    chk({tag, " R7 lanes low in gap"}, busy, 0);
  endtask

  task automatic check_wire(input string tag);
    int mism;
    for (int l = 0; l < L; l++) begin
      chk({tag, " R5 bits per lane"}, dec_n[l], NB);
      mism = 0;
      for (int k = 0; k < NB; k++)
        if (dec[l][k] !== fr[k/24][l*24 + 23 - (k%24)]) mism++;
      chk({tag, " R4 lane data order"}, mism, 0);
    end
    chk({tag, " R2 pulse widths"}, anom, 0);
    chk({tag, " R3 lockstep rises"}, lock_err, 0);
    chk({tag, " R1 bit period"}, per_err, 0);
  endtask

  task automatic t_reset();
    chk("R11 lanes after reset", lanes, 0);
    chk("R11 ready after reset", px_ready, 1);
    chk("R11 done after reset", frame_done, 0);
    chk("R11 underrun after reset", underrun, 0);
    chk("R11 frame_err after reset", frame_err, 0);
  endtask

  task automatic t_frame(input string tag, input logic [L*24-1:0] a, input logic [L*24-1:0] b);
    clear_mon();
    fr[0] = a; fr[1] = b;
    push(a, 1'b1, 1'b0);
    push(b, 1'b0, 1'b1);
    wait_done_and_gap(tag);
    check_wire(tag);
    chk({tag, " R8 no underrun"}, underrun, 0);
    chk({tag, " R10 no frame_err"}, frame_err, 0);
  endtask

  task automatic t_discard();
    int busy;
    busy = 0;
    clear_mon();
    push({L{24'hA5C3F0}}, 1'b0, 1'b0);
    for (int i = 0; i < 50; i++) begin
      @(negedge clk);
      if (lanes != '0) busy++;
    end
    chk("R9 lanes quiet after dropped beat", busy, 0);
    chk("R9 no bits decoded", dec_n[0] + dec_n[L-1], 0);
    chk("R9 ready stays high", px_ready, 1);
  endtask

  task automatic t_underrun();
    int busy;
    busy = 0;
    clear_mon();
    fr[0] = {24'h800001, 24'hFF00FF, 24'h123456, 24'h00FF00, 24'hFFFFFF, 24'hC0FFEE};
    fr[1] = {24'h7E7E7E, 24'h000001, 24'hABCDEF, 24'h101010, 24'h000000, 24'h5A5A5A};
    push(fr[0], 1'b1, 1'b0);
    for (int i = 0; i < 400; i++) begin
      @(negedge clk);
      if (i == 150) chk("R8 underrun low while first pixel sends", underrun, 0);
      if (i >= 300 && lanes != '0) busy++;
    end
    chk("R8 lanes low while starved", busy, 0);
    chk("R8 underrun raised", underrun, 1);
    push(fr[1], 1'b0, 1'b1);
    wait_done_and_gap("underrun");
    check_wire("underrun");
    chk("R8 underrun sticky", underrun, 1);
  endtask

  task automatic t_framing();
    clear_mon();
    fr[0] = {L{24'h0F0F0F}};
    fr[1] = {L{24'hF0F0F0}};
    chk("R10 no frame_err before", frame_err, 0);
    push(fr[0], 1'b1, 1'b1);
    push(fr[1], 1'b0, 1'b0);
    wait_done_and_gap("framing");
    chk("R10 frame_err raised", frame_err, 1);
    chk("R5 framing bits still complete", dec_n[0], NB);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_frame("frameA",
      {24'h00FF80, 24'h112233, 24'h44AA55, 24'hFFFFFF, 24'h000000, 24'h010203},
      {24'h800000, 24'h000080, 24'h008000, 24'hDEADBE, 24'h5A5AA5, 24'hFEDCBA});
    t_frame("frameB",
      {L{24'hFFFFFF}},
      {24'h000000, 24'hFFFFFF, 24'h000000, 24'hFFFFFF, 24'h000000, 24'hFFFFFF});
    t_discard();
    t_underrun();
    t_framing();
    $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_checks++;
    n_fails++;
    $display("FAIL watchdog: actual still running, expected finished");
    $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
    $finish;
  end

endmodule